// File: doc/BRIEF.md
# Externally Clocked Modulus Timer

This block is a 16-bit up-counter that lives on the fast bus clock but advances on rising edges of a slower external clock. Two external clock pins are each passed through their own two-flop synchronizer and rising-edge detector. A select bit then picks which of the two edge streams reaches the counter. The counter runs from zero up to a programmable modulus, wraps to zero and raises an overflow flag. The flag can also drive an interrupt line.

One output-compare channel inverts a pin each time the counter reaches a compare value, so the block works as an integer frequency divider. With compare 0 and modulus 4999, the output period is 10000 external edges, which turns 10 MHz into 1 kHz. Every output edge falls on a bus-clock boundary, so the output carries up to one bus period of jitter relative to the input. The external clock must stay below a quarter of the bus clock rate.

Software reaches the block through a write/read port with combinational read data. Register map (address: contents):
- 0 control: bits [1:0] source select, bit 2 overflow interrupt enable, bit 3 overflow flag, bit 4 pin select.
- 1 counter.
- 2 modulus.
- 3 compare.
- 4 lock: bit 0 is the write-unlock bit.

Top module: `ext_clk_mod_timer`

## Requirements
- R1: After reset the registers read as follows: control 0, counter 0, modulus 16'hFFFF, compare 0, lock 0. The toggle output, overflow flag and interrupt are all 0.
- R2: With source select (control bits [1:0]) at 2'b11, the counter increments once per rising edge of the selected pin. The new value is readable from the third bus clock edge after the pin rises. With any other source value, including 2'b00 and 2'b01, the counter holds.
- R3: Pin select (control bit 4) at 0 takes ext_clk[0] and at 1 takes ext_clk[1]. Edges on the unselected pin do not move the counter.
- R4: The counter counts 0 through the modulus inclusive. On the edge after reaching the modulus it returns to 0 and sets the overflow flag (control bit 3).
- R5: The toggle output inverts on every count edge that leaves the counter equal to the compare value. A compare value above the modulus never toggles it.
- R6: ovf_irq is high exactly while the overflow flag and the interrupt enable (control bit 2) are both 1.
- R7: Writing control with bit 3 at 0 while the flag reads 1 clears the flag. A wrap in the same cycle keeps it set. Writing 1 to bit 3 never sets it.
- R8: While lock bit 0 is 0, writes to modulus, compare, and the source/enable/pin fields of control are ignored. Counter clearing and flag clearing still work.
- R9: Any write to the counter address loads 0, whatever the data. This write wins over a count edge arriving in the same cycle.
- R10: A pin held high for many bus cycles counts once, since only the rising edge counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| ext_clk | input | 2 | Two asynchronous external clock pins |
| toggle_out | output | 1 | Output-compare toggle pin |
| ovf_flag | output | 1 | Overflow flag |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
The bench checks the exact cycle in which a pin edge becomes visible in the counter. A synchronizer that is one stage too short or too long shows up there as a count that appears a cycle early or late.

It lines a flag-clear write and a counter-clear write up with a wrap edge in the same cycle. A design with the wrong priority would lose a real overflow, or would let the count escape the clear.

A pin held high for a long time exposes a level-sensitive design, which would count on every cycle. A modulus of zero and a compare value above the modulus test the wrap and toggle arithmetic at its limits. Writes while locked, and edges on the unselected pin, must leave the readable state untouched.

// File: rtl/emt_pkg.sv
package emt_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd1;
  localparam logic [ADDR_W-1:0] A_MOD   = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMP   = 3'd3;
  localparam logic [ADDR_W-1:0] A_LOCK  = 3'd4;

  localparam int SRC_LO   = 0;
  localparam int IE_BIT   = 2;
  localparam int FLAG_BIT = 3;
  localparam int PIN_BIT  = 4;

  localparam logic [1:0] SRC_OFF = 2'b00;
  localparam logic [1:0] SRC_EXT = 2'b11;
endpackage

// File: rtl/emt_edge_sync.sv
module emt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  // sh[STAGES-1:0] is the synchronizer; sh[STAGES] holds the previous sample
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], pin};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/emt_regs.sv
module emt_regs
  import emt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic              flag,
  output logic              unlock,
  output logic [1:0]        src,
  output logic              ie,
  output logic              pin_sel,
  output logic [CNT_W-1:0]  mod_val,
  output logic [CNT_W-1:0]  cmp_val,
  output logic              cnt_clr,
  output logic              flag_clr
);
  logic wr_ctrl, wr_prot;

  assign wr_ctrl  = wr && (addr == A_CTRL);
  assign wr_prot  = wr && unlock;
  assign cnt_clr  = wr && (addr == A_COUNT);
  assign flag_clr = wr_ctrl && !wdata[FLAG_BIT] && flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlock  <= 1'b0;
      src     <= SRC_OFF;
      ie      <= 1'b0;
      pin_sel <= 1'b0;
      mod_val <= '1;
      cmp_val <= '0;
    end else begin
      if (wr && addr == A_LOCK) unlock <= wdata[0];
      if (wr_prot && addr == A_CTRL) begin
        src     <= wdata[SRC_LO+1:SRC_LO];
        ie      <= wdata[IE_BIT];
        pin_sel <= wdata[PIN_BIT];
      end
      if (wr_prot && addr == A_MOD) mod_val <= wdata;
      if (wr_prot && addr == A_CMP) cmp_val <= wdata;
    end
  end
endmodule

// File: rtl/emt_core.sv
module emt_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cnt_clr,
  input  logic             flag_clr,
  input  logic [CNT_W-1:0] mod_val,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] count,
  output logic             flag,
  output logic             toggle,
  output logic             wrap,
  output logic             match
);
  function automatic logic f_at_limit(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] m);
    return c == m;
  endfunction

  function automatic logic [CNT_W-1:0] f_next(input logic [CNT_W-1:0] c, input logic lim);
    return lim ? '0 : c + 1'b1;
  endfunction

  logic             step;
  logic [CNT_W-1:0] nxt;

  assign step  = tick && !cnt_clr;
  assign wrap  = step && f_at_limit(count, mod_val);
  assign nxt   = f_next(count, f_at_limit(count, mod_val));
  assign match = step && (nxt == cmp_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      flag   <= 1'b0;
      toggle <= 1'b0;
    end else begin
      if (cnt_clr)   count <= '0;
      else if (step) count <= nxt;
      if (wrap)          flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
      if (match) toggle <= ~toggle;
    end
  end
endmodule

// File: rtl/ext_clk_mod_timer.sv
module ext_clk_mod_timer
  import emt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic [1:0]        ext_clk,
  output logic              toggle_out,
  output logic              ovf_flag,
  output logic              ovf_irq
);
  localparam int NUM_PINS = 2;

  logic [NUM_PINS-1:0] rise_vec;
  logic                unlock, ie, pin_sel, cnt_clr, flag_clr;
  logic [1:0]          src;
  logic [CNT_W-1:0]    mod_val, cmp_val, count;
  logic                tick, wrap, match;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    emt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (ext_clk[i]),
      .rise (rise_vec[i])
    );
  end

  assign tick = rise_vec[pin_sel] && (src == SRC_EXT);

  emt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (bus_wr),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .flag    (ovf_flag),
    .unlock  (unlock),
    .src     (src),
    .ie      (ie),
    .pin_sel (pin_sel),
    .mod_val (mod_val),
    .cmp_val (cmp_val),
    .cnt_clr (cnt_clr),
    .flag_clr(flag_clr)
  );

  emt_core #(.CNT_W(CNT_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .cnt_clr (cnt_clr),
    .flag_clr(flag_clr),
    .mod_val (mod_val),
    .cmp_val (cmp_val),
    .count   (count),
    .flag    (ovf_flag),
    .toggle  (toggle_out),
    .wrap    (wrap),
    .match   (match)
  );

  assign ovf_irq = ovf_flag & ie;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[SRC_LO+1:SRC_LO] = src;
        bus_rdata[IE_BIT]          = ie;
        bus_rdata[FLAG_BIT]        = ovf_flag;
        bus_rdata[PIN_BIT]         = pin_sel;
      end
      A_COUNT: bus_rdata    = count;
      A_MOD:   bus_rdata    = mod_val;
      A_CMP:   bus_rdata    = cmp_val;
      A_LOCK:  bus_rdata[0] = unlock;
      default: bus_rdata    = '0;
    endcase
  end
endmodule

// File: rtl/emt_checker.sv
module emt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             cnt_clr,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] mod_val,
  input logic [CNT_W-1:0] cmp_val,
  input logic             flag,
  input logic             toggle,
  input logic             unlock,
  input logic             ie,
  input logic             irq
);
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_clr) |=> $stable(count));

  a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_clr && count == mod_val) |=> (count == '0 && flag));

  a_r7_flag_only_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(tick && !cnt_clr && count == mod_val));

  a_r5_toggle_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (toggle != $past(toggle)) |-> ($past(tick) && count == $past(cmp_val)));

  a_r6_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag && ie));

  a_r8_locked_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !unlock |=> ($stable(mod_val) && $stable(cmp_val)));

  a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (count == '0));

  a_r10_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

bind ext_clk_mod_timer emt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .tick   (tick),
  .cnt_clr(cnt_clr),
  .count  (count),
  .mod_val(mod_val),
  .cmp_val(cmp_val),
  .flag   (ovf_flag),
  .toggle (toggle_out),
  .unlock (unlock),
  .ie     (ie),
  .irq    (ovf_irq)
);

// File: tb/ext_clk_mod_timer_tb.sv
module ext_clk_mod_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [1:0]  ext_clk = '0;
  logic        toggle_out, ovf_flag, ovf_irq;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  ext_clk_mod_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk(ext_clk),
    .toggle_out(toggle_out), .ovf_flag(ovf_flag), .ovf_irq(ovf_irq)
  );

  typedef struct packed {
    logic [15:0] modv;
    logic [15:0] cmpv;
    logic [7:0]  pulses;
    logic [15:0] e_cnt;
    logic        e_tog;
    logic        e_flag;
  } vec_t;

  // expected: count = n mod (M+1); toggles = #k in 1..n with k mod (M+1) == C
  localparam vec_t VEC [0:5] = '{
    '{16'd4, 16'd0, 8'd5,  16'd0, 1'b1, 1'b1},
    '{16'd4, 16'd2, 8'd12, 16'd2, 1'b1, 1'b1},
    '{16'd9, 16'd3, 8'd7,  16'd7, 1'b1, 1'b0},
    '{16'd0, 16'd0, 8'd3,  16'd0, 1'b1, 1'b1},
    '{16'd3, 16'd5, 8'd10, 16'd2, 1'b0, 1'b1},
    '{16'd6, 16'd6, 8'd6,  16'd6, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ext_clk = '0;
    bus_wr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse(input int idx);
    ext_clk[idx] = 1'b1;
    repeat (2) @(negedge clk);
    ext_clk[idx] = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // pin edge whose count event coincides with a bus write
  task automatic pulse_with_write(input logic [2:0] a, input logic [15:0] d);
    ext_clk[0] = 1'b1;
    repeat (2) @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; ext_clk[0] = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    do_reset();

    // R1 reset state
    rd(3'd0, r); chk("R1 ctrl", r, 0);
    rd(3'd1, r); chk("R1 count", r, 0);
    rd(3'd2, r); chk("R1 modulus", r, 16'hFFFF);
    rd(3'd3, r); chk("R1 compare", r, 0);
    rd(3'd4, r); chk("R1 lock", r, 0);
    chk("R1 outputs", {toggle_out, ovf_flag, ovf_irq}, 0);

    // vector table: R4 wrap, R5 toggle
    for (int v = 0; v < 6; v++) begin
      do_reset();
      wr(3'd4, 16'd1);
      wr(3'd2, VEC[v].modv);
      wr(3'd3, VEC[v].cmpv);
      wr(3'd0, 16'h0003);
      for (int p = 0; p < int'(VEC[v].pulses); p++) pulse(0);
      rd(3'd1, r); chk($sformatf("R4 vec%0d count", v), r, VEC[v].e_cnt);
      chk($sformatf("R4 vec%0d flag", v), ovf_flag, VEC[v].e_flag);
      chk($sformatf("R5 vec%0d toggle", v), toggle_out, VEC[v].e_tog);
    end

    // R2 latency of three bus edges
    do_reset();
    wr(3'd4, 16'd1);
    wr(3'd0, 16'h0003);
    ext_clk[0] = 1'b1;
    repeat (2) @(negedge clk);
    rd(3'd1, r); chk("R2 not yet counted after 2 edges", r, 0);
    @(negedge clk);
    rd(3'd1, r); chk("R2 counted after 3 edges", r, 1);
    ext_clk[0] = 1'b0;
    repeat (2) @(negedge clk);

    // R10 long high level counts once
    ext_clk[0] = 1'b1;
    repeat (20) @(negedge clk);
    ext_clk[0] = 1'b0;
    repeat (2) @(negedge clk);
    rd(3'd1, r); chk("R10 held level", r, 2);

    // R3 pin select
    wr(3'd0, 16'h0013);
    pulse(0);
    rd(3'd1, r); chk("R3 unselected pin ignored", r, 2);
    pulse(1);
    rd(3'd1, r); chk("R3 selected pin 1 counts", r, 3);

    // R2 source off / other encodings hold
    wr(3'd0, 16'h0010);
    pulse(1);
    rd(3'd1, r); chk("R2 source 00 holds", r, 3);
    wr(3'd0, 16'h0011);
    pulse(1);
    rd(3'd1, r); chk("R2 source 01 holds", r, 3);

    // R9 counter write loads zero
    wr(3'd0, 16'h0003);
    wr(3'd1, 16'hBEEF);
    rd(3'd1, r); chk("R9 write loads zero", r, 0);
    pulse(0);
    pulse_with_write(3'd1, 16'h0055);
    rd(3'd1, r); chk("R9 clear beats same-cycle edge", r, 0);

    // R7 / R6 flag behaviour
    do_reset();
    wr(3'd4, 16'd1);
    wr(3'd2, 16'd1);
    wr(3'd0, 16'h0003);
    pulse(0); pulse(0); pulse(0);
    chk("R6 irq masked", ovf_irq, 0);
    pulse_with_write(3'd0, 16'h0003);
    rd(3'd0, r); chk("R7 wrap beats clear", r, 16'h000B);
    rd(3'd1, r); chk("R4 wrapped count", r, 0);
    wr(3'd0, 16'h000F);
    chk("R6 irq raised", ovf_irq, 1);
    wr(3'd0, 16'h0007);
    rd(3'd0, r); chk("R7 flag cleared", r, 16'h0007);
    chk("R6 irq drops with flag", ovf_irq, 0);
    wr(3'd0, 16'h000B);
    rd(3'd0, r); chk("R7 writing one does not set", r, 16'h0003);

    // R8 write protection
    do_reset();
    wr(3'd2, 16'd5);
    rd(3'd2, r); chk("R8 locked modulus", r, 16'hFFFF);
    wr(3'd3, 16'd7);
    rd(3'd3, r); chk("R8 locked compare", r, 0);
    wr(3'd0, 16'h0003);
    rd(3'd0, r); chk("R8 locked ctrl", r, 0);
    wr(3'd4, 16'd1);
    wr(3'd0, 16'h0003);
    pulse(0); pulse(0);
    wr(3'd4, 16'd0);
    wr(3'd0, 16'h0000);
    rd(3'd0, r); chk("R8 relocked ctrl", r, 16'h0003);
    wr(3'd1, 16'h0000);
    rd(3'd1, r); chk("R8 count clear while locked", r, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule